// File: doc/BRIEF.md
# Multi-Mode Converter Sequencer

This block is the digital half of a feedback analogue-to-digital converter. It presents a trial code to an external DAC and reads back one comparator bit that is 1 when the sampled input lies above the DAC output. From that bit it works out a digital result with one of three search schemes: an upward count from zero, a follower that steps one code up or down per trial, or a binary search from the most significant bit down.

A start pulse, given while the block is idle, latches the mode, raises the sample-and-hold control and waits a settling time before the first trial code is driven. The comparator is brought into the clock domain through two flip-flops, so every trial code is held for three clocks: two for the synchroniser and one to decide. Ramp and binary-search conversions end with a single-cycle done pulse and hold released. The follower keeps running, refreshing the result and pulsing done on every step, until the mode input leaves the follow setting.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, hold, done, result and dac_code are all 0.
- R2: A start seen while idle raises hold on the next clock. Hold stays high for SETTLE clocks before the first trial code and for the whole conversion, and drops on the clock that completes it.
- R3: The comparator input passes through two flip-flops. Each trial code is held on dac_code for exactly three clocks before the next decision.
- R4: In ramp mode (mode 00) the code counts up from 0 and stops at the first code for which the comparator reads 0. That code becomes the result.
- R5: In ramp mode, if the comparator never reads 0, the count stops at all ones and all ones is the result.
- R6: In binary-search mode (mode 10, and also mode 11), bits are tried from the MSB down. A bit is kept when the comparator reads 1. The result is the largest code below the input, or 0. Done rises SETTLE+3*W clocks after the clock that accepted start.
- R7: In follow mode (mode 01) the code starts from the previous result and moves one step toward the input per trial, clamped at 0 and at all ones. Result and done update on every trial. When mode leaves 01 the block returns to idle with hold low.
- R8: In ramp and binary-search modes, done is high for exactly one clock per conversion.
- R9: A start asserted while a conversion is running has no effect, including a change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| mode | input | 2 | 00 ramp, 01 follow, 10/11 binary search |
| cmp_in | input | 1 | Comparator, 1 when input is above DAC output |
| dac_code | output | W | Trial code to the DAC |
| hold | output | 1 | Sample-and-hold control, 1 = hold |
| result | output | W | Last conversion result |
| done | output | 1 | Result update pulse |

## Verification
Assertions check on every clock that hold is high while trial codes are applied, that a trial code stays put until its decision clock, that the ramp never counts down and that the follower never jumps by more than one code. They also check that a terminating conversion pulses done for a single clock and that the latched mode stays fixed while busy. Only the bench scenarios can show that the numeric results match each search rule against a modelled input, including saturation and the zero input. The same goes for the exact latency of a binary search, the convergence of the follower and its exit, and the fact that a mid-conversion start does not change the answer.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int W      = 8,
  parameter int SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic         cmp_in,
  output logic [W-1:0] dac_code,
  output logic         hold,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [1:0] M_RAMP = 2'b00;
  localparam logic [1:0] M_TRK  = 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CONV} st_t;

  st_t          st;
  logic [1:0]   mode_r, ph, sync;
  logic [SW-1:0] cnt;
  logic [W-1:0] code, res, bitsel, trk_nxt, sar_kept;
  logic         hold_r, done_r;

  wire cmp_s  = sync[1];
  wire is_trk = (mode_r == M_TRK);
  wire is_rmp = (mode_r == M_RAMP);
  wire full   = &code;

  always_comb begin
    if (cmp_s) trk_nxt = full ? code : code + W'(1);
    else       trk_nxt = (code == '0) ? code : code - W'(1);
    sar_kept = cmp_s ? code : (code & ~bitsel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_r <= '0; ph <= '0; sync <= '0; cnt <= '0;
      code <= '0; res <= '0; bitsel <= '0; hold_r <= 1'b0; done_r <= 1'b0;
    end else begin
      sync   <= {sync[0], cmp_in};
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETTLE; hold_r <= 1'b1; cnt <= '0; mode_r <= mode;
        end
        S_SETTLE: if (cnt == SW'(SETTLE - 1)) begin
          st <= S_CONV; ph <= '0;
          if (is_rmp)      code <= '0;
          else if (is_trk) code <= res;
          else begin
            code   <= W'(1) << (W - 1);
            bitsel <= W'(1) << (W - 1);
          end
        end else cnt <= cnt + SW'(1);
        S_CONV: if (is_trk && mode != M_TRK) begin
          st <= S_IDLE; hold_r <= 1'b0;
        end else if (ph != 2'd2) begin
          ph <= ph + 2'd1;
        end else begin
          ph <= '0;
          if (is_rmp) begin
            if (cmp_s && !full) code <= code + W'(1);
            else begin
              res <= code; st <= S_IDLE; hold_r <= 1'b0; done_r <= 1'b1;
            end
          end else if (is_trk) begin
            code <= trk_nxt; res <= trk_nxt; done_r <= 1'b1;
          end else if (bitsel[0]) begin
            code <= sar_kept; res <= sar_kept;
            st <= S_IDLE; hold_r <= 1'b0; done_r <= 1'b1;
          end else begin
            code   <= sar_kept | (bitsel >> 1);
            bitsel <= bitsel >> 1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dac_code = code;
  assign result   = res;
  assign hold     = hold_r;
  assign done     = done_r;

  AST_HOLD_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> hold); // R2
  AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && ph != 2'd2) |=> $stable(dac_code)); // R3
  AST_RAMP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && is_rmp) |=> (dac_code >= $past(dac_code))); // R4
  AST_TRK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV && is_trk) |=> (dac_code == $past(dac_code) ||
      dac_code == $past(dac_code) + W'(1) || dac_code == $past(dac_code) - W'(1))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !is_trk) |=> !done); // R8
  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> $stable(mode_r)); // R9
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int W = 8, SETTLE = 4;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] mode = 0;
  logic [W-1:0] dac_code, result;
  logic hold, done;
  int vin = 0;
  int errors = 0, checks = 0, cyc = 0;
  wire cmp_in = (vin > int'(dac_code));

  always #10 clk = ~clk;

  adc_seq_ctrl #(.W(W), .SETTLE(SETTLE)) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cmp_in(cmp_in),
    .dac_code(dac_code), .hold(hold), .result(result), .done(done));

  function automatic int exp_ramp(int v);
    return (v > 255) ? 255 : v;
  endfunction
  function automatic int exp_sar(int v);
    if (v <= 0) return 0;
    return (v - 1 > 255) ? 255 : v - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  task automatic convert(input logic [1:0] m, input int v, input bit poke,
                         output int n, output bit hold_ok);
    vin = v; mode = m;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 1; hold_ok = hold;
    while (!done && n < 2000) begin
      if (poke && n == 20) begin start = 1; mode = 2'b10; end
      else start = 0;
      @(negedge clk); n++;
      if (!done && !hold) hold_ok = 0;
    end
    start = 0;
  endtask

  int n, r, prev;
  bit hok;
  initial begin
    repeat (3) @(negedge clk);
    chk(hold == 0 && done == 0 && result == 0 && dac_code == 0, "R1", int'(result), 0);
    rst_n = 1;
    @(negedge clk);

    convert(2'b10, 100, 0, n, hok);
    chk(int'(result) == exp_sar(100), "R6", int'(result), exp_sar(100));
    chk(n == SETTLE + 3 * W + 1, "R6 latency", n, SETTLE + 3 * W + 1);
    chk(hok, "R2 hold held", 0, 1);
    @(negedge clk);
    chk(done == 0, "R8", int'(done), 0);
    chk(hold == 0, "R2 release", int'(hold), 0);

    convert(2'b00, 0, 0, n, hok);
    chk(int'(result) == 0, "R4 zero", int'(result), 0);
    convert(2'b00, 255, 0, n, hok);
    chk(int'(result) == 255, "R4 top", int'(result), 255);
    convert(2'b00, 300, 0, n, hok);
    chk(int'(result) == 255, "R5 saturate", int'(result), 255);
    chk(n == SETTLE + 3 * 256 + 1, "R3 step time", n, SETTLE + 3 * 256 + 1);
    convert(2'b11, 0, 0, n, hok);
    chk(int'(result) == 0, "R6 zero", int'(result), 0);
    convert(2'b00, 50, 1, n, hok);
    chk(int'(result) == exp_ramp(50), "R9 start ignored", int'(result), exp_ramp(50));

    convert(2'b10, 100, 0, n, hok);
    vin = 105; mode = 2'b01;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    prev = int'(result);
    for (int k = 0; k < 12; k++) begin
      int t = 0;
      while (!done && t < 100) begin @(negedge clk); t++; end
      r = int'(result);
      if (k == 0) chk(r == 100, "R7 first step", r, 100);
      chk(r - prev <= 1 && prev - r <= 1, "R7 step size", r, prev);
      prev = r;
      @(negedge clk);
    end
    chk(prev == 104 || prev == 105, "R7 converge", prev, 105);
    mode = 2'b00;
    @(negedge clk);
    chk(hold == 0, "R7 exit", int'(hold), 0);

    for (int i = 0; i < 20; i++) begin
      logic [1:0] m;
      int v;
      m = ($urandom % 2) ? 2'b10 : 2'b00;
      v = $urandom % 256;
      convert(m, v, 0, n, hok);
      r = (m == 2'b00) ? exp_ramp(v) : exp_sar(v);
      chk(int'(result) == r, m == 2'b00 ? "R4 random" : "R6 random", int'(result), r);
      chk(hok, "R2 random hold", 0, 1);
    end
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule